// File: doc/BRIEF.md
# Self-Recovering Maximal-Length PN Sequence Generator

This block produces a pseudo-noise bit stream from a Fibonacci shift register. The register is `WIDTH` stages long, and each width has one fixed primitive feedback polynomial. On every enabled clock the register shifts one place toward its top stage. A feedback bit enters at the bottom. The top stage is the serial PN output, and the whole state word is also brought out.

The feedback is either the parity of the tapped stages (XOR form) or its complement (XNOR form), chosen by `xnor_sel`. Each form has exactly one state that maps to itself:
- all-zeros for the XOR form;
- all-ones for the XNOR form.

A detector watches for the lockup state of the selected form at all times. When it sees that state, it overrides the feedback bit so the register leaves the state on the next enabled clock. This covers a corrupted state or a mode change, not only reset.

Reset clears every flip-flop. One stage is stored inverted, so the cleared register reads as a seed with a single 1. Inside the maximal-length cycle the detector never fires, so the period stays `2^WIDTH - 1`.

The output is a free-running bit with no handshake. A consumer that needs back-pressure gates `en`; while `en` is low, nothing advances.

Top module: `pn_lfsr_gen`

## Requirements
- R1: A clock edge with `rst` high loads the seed `1 << SEED_BIT` into `state_word` (8'h01 by default), so `pn_bit` reads 0.
- R2: `rst` wins over `en`: with both high, the seed is loaded and no shift happens.
- R3: With `en` low and `rst` low, `state_word` and `pn_bit` keep their values.
- R4: On an enabled clock, the new `state_word[WIDTH-1:1]` equals the old `state_word[WIDTH-2:0]`, and `pn_bit` always equals `state_word[WIDTH-1]`.
- R5: With `xnor_sel` low and the state not all-zeros, the new bit 0 is the parity of the state ANDed with the tap mask. For WIDTH=8 the mask is 8'hB8 (bits 7,5,4,3; polynomial x^8+x^6+x^5+x^4+1).
- R6: With `xnor_sel` high and the state not all-ones, the new bit 0 is the complement of that parity.
- R7: In XOR form, starting from the seed, the register visits `2^WIDTH - 1` distinct nonzero states and is back at the seed after exactly that many enabled clocks.
- R8: In XNOR form, starting from the seed, the register visits `2^WIDTH - 1` distinct states, none of them all-ones, and is back at the seed after exactly that many enabled clocks.
- R9: In XOR form, an all-zeros state moves to 8'h01 (a single 1 in bit 0) on the next enabled clock. This holds when the state was reached through a mode change mid-run.
- R10: In XNOR form, an all-ones state moves to 8'hFE (a single 0 in bit 0) on the next enabled clock. This holds when the state was reached through a mode change mid-run.
- R11: A change of `xnor_sel` takes effect on the very next enabled clock and needs no reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high, loads the seed |
| en | input | 1 | Advance enable; low holds the state |
| xnor_sel | input | 1 | 0 selects XOR feedback, 1 selects XNOR feedback |
| pn_bit | output | 1 | Serial PN output (top stage) |
| state_word | output | WIDTH | Logical register contents |

## Verification
A wrong stored stage shows on `state_word` right away. It reaches `pn_bit` after at most `WIDTH-1` enabled clocks, when it has shifted into the top stage.

A wrong tap or a wrong polynomial does not show at the first step. It appears as a shortened or repeating period, so the whole cycle is swept in both feedback forms, and every state is checked for uniqueness and against its arithmetic successor.

A missing escape shows as a frozen output from the cycle after lockup onward. Lockup is reached through the ports, by changing the mode at the one cycle state where the other form's lockup lies, and the escape is checked one clock later.

// File: rtl/pn_lfsr_pkg.sv
package pn_lfsr_pkg;

  localparam int MAX_W = 64;

  // Primitive-polynomial tap masks, bit i set means stage i feeds back.
  function automatic logic [MAX_W-1:0] tap_mask(input int w);
    logic [MAX_W-1:0] m;
    m = '0;
    case (w)
      3:  m[2:0]  = 3'b110;
      4:  m[3:0]  = 4'b1100;
      5:  m[4:0]  = 5'b10100;
      6:  m[5:0]  = 6'b110000;
      7:  m[6:0]  = 7'b1100000;
      8:  m[7:0]  = 8'hB8;
      16: m[15:0] = 16'hD008;
      default: m = '0;
    endcase
    return m;
  endfunction

  typedef enum logic {FB_XOR = 1'b0, FB_XNOR = 1'b1} fb_form_e;

endpackage

// File: rtl/pn_lfsr_feedback.sv
module pn_lfsr_feedback #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] cur_state,
  input  logic             xnor_sel,
  output logic             fb_raw
);
  import pn_lfsr_pkg::*;

  localparam logic [MAX_W-1:0] FULL_MASK = tap_mask(WIDTH);
  localparam logic [WIDTH-1:0] TAPS      = FULL_MASK[WIDTH-1:0];

  generate
    if (TAPS == '0) begin : g_bad_width
      initial $error("pn_lfsr_feedback: no tap set for WIDTH=%0d", WIDTH);
    end
  endgenerate

  logic [WIDTH-1:0] tapped;
  logic             parity;

  always_comb begin
    tapped = cur_state & TAPS;
    parity = ^tapped;
    fb_raw = (fb_form_e'(xnor_sel) == FB_XNOR) ? ~parity : parity;
  end

endmodule

// File: rtl/pn_lfsr_escape.sv
module pn_lfsr_escape #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] cur_state,
  input  logic             xnor_sel,
  input  logic             fb_raw,
  output logic             fb_fixed,
  output logic             stuck
);
  logic zeros_seen;
  logic ones_seen;

  always_comb begin
    zeros_seen = ~|cur_state;   // wide NOR
    ones_seen  = &cur_state;    // wide AND
    if (xnor_sel) begin
      stuck    = ones_seen;
      fb_fixed = fb_raw & ~ones_seen;
    end else begin
      stuck    = zeros_seen;
      fb_fixed = fb_raw | zeros_seen;
    end
  end

endmodule

// File: rtl/pn_lfsr_store.sv
module pn_lfsr_store #(
  parameter int WIDTH    = 8,
  parameter int SEED_BIT = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [WIDTH-1:0] nxt_logical,
  output logic [WIDTH-1:0] cur_logical
);
  localparam logic [WIDTH-1:0] INV_MASK = WIDTH'(1) << SEED_BIT;

  generate
    if (SEED_BIT < 0 || SEED_BIT >= WIDTH) begin : g_bad_seed
      initial $error("pn_lfsr_store: SEED_BIT out of range");
    end
  endgenerate

  logic [WIDTH-1:0] phys_q;

  always_ff @(posedge clk) begin
    if (rst)
      phys_q <= '0;
    else if (en)
      phys_q <= nxt_logical ^ INV_MASK;
  end

  assign cur_logical = phys_q ^ INV_MASK;

endmodule

// File: rtl/pn_lfsr_gen.sv
module pn_lfsr_gen #(
  parameter int WIDTH    = 8,
  parameter int SEED_BIT = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             xnor_sel,
  output logic             pn_bit,
  output logic [WIDTH-1:0] state_word
);
  localparam logic [WIDTH-1:0] ALL_ONES = '1;
  localparam logic [WIDTH-1:0] SEED     = WIDTH'(1) << SEED_BIT;

  logic [WIDTH-1:0] cur_state;
  logic [WIDTH-1:0] nxt_state;
  logic             fb_raw;
  logic             fb_fixed;
  logic             stuck;

  pn_lfsr_feedback #(.WIDTH(WIDTH)) u_fb (
    .cur_state (cur_state),
    .xnor_sel  (xnor_sel),
    .fb_raw    (fb_raw)
  );

  pn_lfsr_escape #(.WIDTH(WIDTH)) u_esc (
    .cur_state (cur_state),
    .xnor_sel  (xnor_sel),
    .fb_raw    (fb_raw),
    .fb_fixed  (fb_fixed),
    .stuck     (stuck)
  );

  assign nxt_state = {cur_state[WIDTH-2:0], fb_fixed};

  pn_lfsr_store #(.WIDTH(WIDTH), .SEED_BIT(SEED_BIT)) u_store (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .nxt_logical (nxt_state),
    .cur_logical (cur_state)
  );

  assign state_word = cur_state;
  assign pn_bit     = cur_state[WIDTH-1];

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(state_word)); // R3

  AST_SHIFT_UP: assert property (@(posedge clk) disable iff (rst)
    en |=> state_word[WIDTH-1:1] == $past(state_word[WIDTH-2:0])); // R4

  AST_XOR_NO_STICK: assert property (@(posedge clk) disable iff (rst)
    (en && !xnor_sel && state_word == '0) |=> state_word == WIDTH'(1)); // R9

  AST_XNOR_NO_STICK: assert property (@(posedge clk) disable iff (rst)
    (en && xnor_sel && state_word == ALL_ONES) |=> state_word == (ALL_ONES ^ WIDTH'(1))); // R10

  AST_ESCAPE_ONLY_AT_LOCK: assert property (@(posedge clk) disable iff (rst)
    (en && !stuck) |=> state_word != $past(state_word) || $past(state_word) == '0 || $past(state_word) == ALL_ONES); // R7

  AST_SEED_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> state_word == SEED || $past(en)); // R1

endmodule

// File: tb/sim_pn_lfsr_gen.sv
module sim_pn_lfsr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int PERIOD = (1 << W) - 1;
  localparam logic [W-1:0] TAPS = 8'hB8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic xnor_sel = 1'b0;
  logic pn_bit;
  logic [W-1:0] state_word;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pn_lfsr_gen #(.WIDTH(W), .SEED_BIT(0)) u0 (
    .clk(clk), .rst(rst), .en(en), .xnor_sel(xnor_sel),
    .pn_bit(pn_bit), .state_word(state_word)
  );

  function automatic logic [W-1:0] succ(input logic [W-1:0] s, input logic xm);
    logic b;
    b = (^(s & TAPS)) ^ xm;
    if (!xm && s == '0) b = 1'b1;
    if (xm && s == '1) b = 1'b0;
    return {s[W-2:0], b};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic xm);
    rst = 1'b1; en = 1'b1; xnor_sel = xm;
    tick();
    chk(state_word == 8'h01, "R1 seed", state_word, 8'h01);
    chk(pn_bit == 1'b0, "R1 pn_bit", pn_bit, 0);
    rst = 1'b0;
  endtask

  task automatic sweep(input logic xm);
    logic [255:0] seen;
    logic [W-1:0] prev;
    int fails_local;
    seen = '0;
    fails_local = 0;
    do_reset(xm);
    seen[state_word] = 1'b1;
    en = 1'b1;
    for (int i = 1; i <= PERIOD; i++) begin
      prev = state_word;
      tick();
      if (state_word != succ(prev, xm)) begin
        chk(0, xm ? "R6 xnor successor" : "R5 xor successor", state_word, succ(prev, xm));
        fails_local++;
      end
      if (pn_bit != state_word[W-1]) begin
        chk(0, "R4 pn_bit is top stage", pn_bit, state_word[W-1]);
        fails_local++;
      end
      if (i < PERIOD) begin
        if (seen[state_word] || (!xm && state_word == '0) || (xm && state_word == '1)) begin
          chk(0, xm ? "R8 repeat or lockup" : "R7 repeat or lockup", state_word, prev);
          fails_local++;
        end
        seen[state_word] = 1'b1;
      end
    end
    chk(fails_local == 0, xm ? "R6 R8 sweep clean" : "R5 R7 sweep clean", fails_local, 0);
    chk(state_word == 8'h01, xm ? "R8 period" : "R7 period", state_word, 8'h01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] held;
    #1;
    do_reset(1'b0);

    // R4: first shift from seed in XOR form
    en = 1'b1;
    tick();
    chk(state_word == 8'h02, "R4 first shift", state_word, 8'h02);
    tick(); tick();
    chk(state_word == 8'h08, "R4 third shift", state_word, 8'h08);

    // R3: hold while idle
    held = state_word;
    en = 1'b0;
    for (int k = 0; k < 5; k++) begin
      tick();
      chk(state_word == held, "R3 hold", state_word, held);
    end
    chk(pn_bit == held[W-1], "R3 pn_bit hold", pn_bit, held[W-1]);

    // R2: reset beats enable
    rst = 1'b1; en = 1'b1;
    tick();
    chk(state_word == 8'h01, "R2 reset priority", state_word, 8'h01);
    rst = 1'b0;

    sweep(1'b0);
    sweep(1'b1);

    // R9 + R11: reach all-zeros in XNOR form, switch to XOR
    do_reset(1'b1);
    en = 1'b1;
    for (int i = 0; i < PERIOD && state_word != '0; i++) tick();
    chk(state_word == '0, "R9 reached zero", state_word, 0);
    xnor_sel = 1'b0;
    tick();
    chk(state_word == 8'h01, "R9 escape zero", state_word, 8'h01);
    tick();
    chk(state_word == 8'h02, "R9 R11 resumes xor", state_word, 8'h02);

    // R10 + R11: reach all-ones in XOR form, switch to XNOR
    do_reset(1'b0);
    en = 1'b1;
    for (int i = 0; i < PERIOD && state_word != 8'hFF; i++) tick();
    chk(state_word == 8'hFF, "R10 reached ones", state_word, 8'hFF);
    xnor_sel = 1'b1;
    tick();
    chk(state_word == 8'hFE, "R10 escape ones", state_word, 8'hFE);
    held = state_word;
    tick();
    chk(state_word == succ(held, 1'b1), "R10 R11 resumes xnor", state_word, succ(held, 1'b1));

    // R11: mode change with en low has no effect until an enabled clock
    en = 1'b0; xnor_sel = 1'b0;
    held = state_word;
    tick();
    chk(state_word == held, "R11 idle mode change", state_word, held);
    en = 1'b1;
    tick();
    chk(state_word == succ(held, 1'b0), "R11 xor next", state_word, succ(held, 1'b0));

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule